// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns the upper bits of a bus transfer address into one of six active-low device selects. Each select has a programmable base and a don't-care mask, which together define its address window. Each also has a set of attributes: an enable, a port-size code, a burst-capable flag, a wait-state count, and a choice between internal and external termination. When a transfer starts, the block picks the lowest-numbered enabled select whose window contains the address. It holds that select low until the transfer is acknowledged. For internal termination, it creates the acknowledge itself once the programmed wait states have elapsed. For external termination, it passes on the device's acknowledge.

Reset clears every select's programming and enables only select 0. Select 0 then behaves as a boot select that answers any address. Its port size and termination mode are taken from three configuration pins, whose level during reset is held when reset is released. The first write to select 0's base register ends this boot behaviour, and select 0 then matches by base and mask like the others. Software programs the block through a single-cycle write port that names a select, a field and a data word.

Top module: `chipsel_unit`

## Requirements
- R1: Directly after reset, every `cs_n` bit is 1 and `xfer_ack` is 0. Reset clears base, mask and attributes of every select, and leaves every select except select 0 disabled.
- R2: Directly after reset, select 0 matches every address. Its port size equals `boot_cfg[1:0]` and its termination is internal when `boot_cfg[2]` is 1, using the pin levels present during reset; its wait count is 0.
- R3: A write to select 0's base field ends the match-any behaviour; from then on select 0 matches through base and mask.
- R4: Select i matches when `((xfer_addr_hi ^ base_i) & ~mask_i) == 0`; a mask bit of 1 excludes that address bit from comparison.
- R5: A select whose enable bit is 0 never asserts, whatever the address.
- R6: When several enabled selects match, only the lowest-numbered one asserts.
- R7: A start whose address matches no enabled select asserts no `cs_n` bit and no `xfer_ack`.
- R8: With internal termination and wait count W, `cs_n` is low for W+1 cycles following the start edge; `xfer_ack` is 1 in the last of these cycles only; `ext_ack` is ignored.
- R9: With external termination, the select stays low and `xfer_ack` equals `ext_ack` (combinationally) until `ext_ack` is seen high at a clock edge.
- R10: At most one `cs_n` bit is low at any time; the select is stable during a transfer and is released in the cycle after `xfer_ack`.
- R11: A `xfer_start` pulse that arrives while a transfer is in progress is ignored.
- R12: During a transfer, `xfer_psize` and `xfer_burst` show the selected device's port size and burst flag; they are 0 when idle.
- R13: A write with `reg_we`=1 targets select `reg_sel`; `reg_field` 0 is base, 1 is mask, 2 is attributes, 3 is ignored. The attribute word is laid out as: bit 0 enable, bits 2:1 port size, bit 3 burst, bit 4 internal termination, bits 15:5 wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_cfg | input | 3 | Boot select configuration pins: [1:0] port size, [2] internal termination |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Select index addressed by the write |
| reg_field | input | 2 | Field addressed: 0 base, 1 mask, 2 attributes |
| reg_wdata | input | 16 | Write data |
| xfer_start | input | 1 | One-cycle pulse marking the start of a transfer |
| xfer_addr_hi | input | 16 | Upper transfer address bits, valid with the start |
| ext_ack | input | 1 | Acknowledge from an externally terminated device |
| cs_n | output | 6 | Active-low device selects |
| xfer_ack | output | 1 | Transfer acknowledge |
| xfer_psize | output | 2 | Port size of the selected device |
| xfer_burst | output | 1 | Burst-capable flag of the selected device |

## Verification
The decoder is driven with addresses that check the window logic in several ways. A boot-time address arbitrary enough that only match-any can explain a hit. An address that differs from a base only in masked bits, and one that differs in an unmasked bit, which together separate the mask from an exact compare. An address that lands in two overlapping windows, which exposes the priority order. Addresses that land only in a disabled window or in no window. Transfers with a nonzero wait count and with external termination separate acknowledge timing from select timing, and a start pulse sent during a busy transfer shows whether the held select can be disturbed.

// File: rtl/csel_pkg.sv
// Package: csel_pkg
// Shared field codes and attribute-word bit positions for the chip-select
// decoder. Assumes the attribute word is at least CTRL_WAIT_LO+1 bits wide.
package csel_pkg;

    // Register field addressed by a write
    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_NONE = 2'd3
    } csel_field_e;

    // Bit positions inside the attribute word
    localparam int CTRL_EN      = 0;
    localparam int CTRL_PS_LO   = 1;
    localparam int PS_W         = 2;
    localparam int CTRL_BURST   = 3;
    localparam int CTRL_INT     = 4;
    localparam int CTRL_WAIT_LO = 5;

    // Boot configuration pin positions
    localparam int BOOT_INT_BIT = 2;

endpackage

// File: rtl/csel_regs.sv
// Module: csel_regs
// Holds base, mask and attributes for each chip select plus the boot
// match-any flag. Sync active-low reset clears all programming; select 0
// comes out enabled with port size and termination taken from the boot
// pins, which are sampled every reset cycle so the last level is kept.
// Assumes reg_sel values >= NUM_CS address nothing.
module csel_regs
    import csel_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int CMP_W  = 16,
    parameter int IDX_W  = 3,
    parameter int WAIT_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               boot_cfg,
    input  logic                     reg_we,
    input  logic [IDX_W-1:0]         reg_sel,
    input  logic [1:0]               reg_field,
    input  logic [CMP_W-1:0]         reg_wdata,
    output logic [CMP_W-1:0]         base_q   [NUM_CS],
    output logic [CMP_W-1:0]         mask_q   [NUM_CS],
    output logic                     en_q     [NUM_CS],
    output logic [PS_W-1:0]          psize_q  [NUM_CS],
    output logic                     burst_q  [NUM_CS],
    output logic                     int_q    [NUM_CS],
    output logic [WAIT_W-1:0]        waits_q  [NUM_CS],
    output logic                     boot_any_q
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        localparam bit IS_BOOT = (i == 0);
        logic hit_wr;

        assign hit_wr = reg_we && (reg_sel == IDX_W'(i));

        // Per-select register storage with reset defaults
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i]  <= '0;
                mask_q[i]  <= '0;
                en_q[i]    <= IS_BOOT;
                psize_q[i] <= IS_BOOT ? boot_cfg[PS_W-1:0] : '0;
                burst_q[i] <= 1'b0;
                int_q[i]   <= IS_BOOT & boot_cfg[BOOT_INT_BIT];
                waits_q[i] <= '0;
            end else if (hit_wr) begin
                case (reg_field)
                    FLD_BASE: base_q[i] <= reg_wdata;
                    FLD_MASK: mask_q[i] <= reg_wdata;
                    FLD_CTRL: begin
                        en_q[i]    <= reg_wdata[CTRL_EN];
                        psize_q[i] <= reg_wdata[CTRL_PS_LO +: PS_W];
                        burst_q[i] <= reg_wdata[CTRL_BURST];
                        int_q[i]   <= reg_wdata[CTRL_INT];
                        waits_q[i] <= reg_wdata[CTRL_WAIT_LO +: WAIT_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Boot match-any flag: set by reset, cleared by select 0 base write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_any_q <= 1'b1;
        end else if (reg_we && reg_sel == '0 && reg_field == FLD_BASE) begin
            boot_any_q <= 1'b0;
        end
    end

endmodule

// File: rtl/csel_match.sv
// Module: csel_match
// Compares the transfer address against every enabled window in parallel
// and resolves overlaps by fixed priority, lowest index first. Select 0
// matches anything while the boot flag is set. Purely combinational.
module csel_match #(
    parameter int NUM_CS = 6,
    parameter int CMP_W  = 16,
    parameter int IDX_W  = 3
) (
    input  logic [CMP_W-1:0] addr,
    input  logic [CMP_W-1:0] base_q [NUM_CS],
    input  logic [CMP_W-1:0] mask_q [NUM_CS],
    input  logic             en_q   [NUM_CS],
    input  logic             boot_any_q,
    output logic             hit_any,
    output logic [IDX_W-1:0] hit_idx
);

    logic [NUM_CS-1:0] raw_hit;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        logic window_ok;
        assign window_ok = (((addr ^ base_q[i]) & ~mask_q[i]) == '0);
        if (i == 0) begin : g_boot
            assign raw_hit[i] = en_q[i] && (window_ok || boot_any_q);
        end else begin : g_plain
            assign raw_hit[i] = en_q[i] && window_ok;
        end
    end

    assign hit_any = |raw_hit;

    // Priority encode: scanning downward leaves the lowest hit index
    always_comb begin
        hit_idx = '0;
        for (int k = NUM_CS - 1; k >= 0; k--) begin
            if (raw_hit[k]) begin
                hit_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/csel_xfer.sv
// Module: csel_xfer
// Transfer sequencer: captures the winning select and its attributes on a
// start pulse, holds that select low, counts wait states for internally
// terminated devices and forwards the external acknowledge otherwise.
// Assumes start pulses during a busy transfer are to be ignored.
module csel_xfer #(
    parameter int NUM_CS = 6,
    parameter int IDX_W  = 3,
    parameter int PS_W   = 2,
    parameter int WAIT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hit_any,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [PS_W-1:0]   sel_psize,
    input  logic              sel_burst,
    input  logic              sel_int,
    input  logic [WAIT_W-1:0] sel_waits,
    input  logic              ext_ack,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ack,
    output logic [PS_W-1:0]   out_psize,
    output logic              out_burst
);

    logic              busy_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              int_q;
    logic [PS_W-1:0]   ps_q;
    logic              burst_q;

    // Acknowledge: wait count exhausted, or device acknowledge passed through
    assign ack = busy_q && (int_q ? (cnt_q == '0) : ext_ack);

    // Transfer state: load on start, count down, end on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            cnt_q   <= '0;
            int_q   <= 1'b0;
            ps_q    <= '0;
            burst_q <= 1'b0;
        end else if (busy_q) begin
            if (ack) begin
                busy_q <= 1'b0;
            end else if (int_q && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start && hit_any) begin
            busy_q  <= 1'b1;
            idx_q   <= hit_idx;
            cnt_q   <= sel_waits;
            int_q   <= sel_int;
            ps_q    <= sel_psize;
            burst_q <= sel_burst;
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_out
        assign cs_n[i] = !(busy_q && idx_q == IDX_W'(i));
    end

    assign out_psize = busy_q ? ps_q : '0;
    assign out_burst = busy_q && burst_q;

endmodule

// File: rtl/chipsel_unit.sv
// Module: chipsel_unit
// Top of the programmable chip-select decoder: register file, parallel
// window match with priority, and the transfer sequencer. Assumes the
// caller presents only the address bits above the window granularity.
module chipsel_unit
    import csel_pkg::*;
#(
    parameter int  NUM_CS = 6,
    parameter int  CMP_W  = 16,
    localparam int IDX_W  = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        boot_cfg,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic [1:0]        reg_field,
    input  logic [CMP_W-1:0]  reg_wdata,
    input  logic              xfer_start,
    input  logic [CMP_W-1:0]  xfer_addr_hi,
    input  logic              ext_ack,
    output logic [NUM_CS-1:0] cs_n,
    output logic              xfer_ack,
    output logic [1:0]        xfer_psize,
    output logic              xfer_burst
);

    localparam int WAIT_W = CMP_W - CTRL_WAIT_LO;

    logic [CMP_W-1:0]  base_q  [NUM_CS];
    logic [CMP_W-1:0]  mask_q  [NUM_CS];
    logic              en_q    [NUM_CS];
    logic [PS_W-1:0]   psize_q [NUM_CS];
    logic              burst_q [NUM_CS];
    logic              int_q   [NUM_CS];
    logic [WAIT_W-1:0] waits_q [NUM_CS];
    logic              boot_any_q;
    logic              hit_any;
    logic [IDX_W-1:0]  hit_idx;
    logic [PS_W-1:0]   sel_psize;
    logic              sel_burst;
    logic              sel_int;
    logic [WAIT_W-1:0] sel_waits;

    csel_regs #(
        .NUM_CS(NUM_CS), .CMP_W(CMP_W), .IDX_W(IDX_W), .WAIT_W(WAIT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_cfg   (boot_cfg),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_field  (reg_field),
        .reg_wdata  (reg_wdata),
        .base_q     (base_q),
        .mask_q     (mask_q),
        .en_q       (en_q),
        .psize_q    (psize_q),
        .burst_q    (burst_q),
        .int_q      (int_q),
        .waits_q    (waits_q),
        .boot_any_q (boot_any_q)
    );

    csel_match #(
        .NUM_CS(NUM_CS), .CMP_W(CMP_W), .IDX_W(IDX_W)
    ) u_match (
        .addr       (xfer_addr_hi),
        .base_q     (base_q),
        .mask_q     (mask_q),
        .en_q       (en_q),
        .boot_any_q (boot_any_q),
        .hit_any    (hit_any),
        .hit_idx    (hit_idx)
    );

    // Attribute mux: pick the winning select's settings
    always_comb begin
        sel_psize = '0;
        sel_burst = 1'b0;
        sel_int   = 1'b0;
        sel_waits = '0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (hit_idx == IDX_W'(k)) begin
                sel_psize = psize_q[k];
                sel_burst = burst_q[k];
                sel_int   = int_q[k];
                sel_waits = waits_q[k];
            end
        end
    end

    csel_xfer #(
        .NUM_CS(NUM_CS), .IDX_W(IDX_W), .PS_W(PS_W), .WAIT_W(WAIT_W)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .sel_psize (sel_psize),
        .sel_burst (sel_burst),
        .sel_int   (sel_int),
        .sel_waits (sel_waits),
        .ext_ack   (ext_ack),
        .cs_n      (cs_n),
        .ack       (xfer_ack),
        .out_psize (xfer_psize),
        .out_burst (xfer_burst)
    );

endmodule

// File: rtl/csel_checker.sv
// Module: csel_checker
// Temporal checks on the decoder's port behaviour, bound to chipsel_unit.
// Assumes rst_n is low from time zero.
module csel_checker #(
    parameter int NUM_CS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_start,
    input logic [NUM_CS-1:0] cs_n,
    input logic              xfer_ack
);

    // R10: never more than one select low
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R8: acknowledge only inside a transfer
    a_r8_ack_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> !(&cs_n));

    // R10: select released the cycle after acknowledge
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> (&cs_n));

    // R11: select stays put until acknowledged
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_ack && !(&cs_n)) |=> $stable(cs_n));

    // R7: no select appears without a start
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cs_n) && !xfer_start) |=> (&cs_n));

endmodule

bind chipsel_unit csel_checker #(.NUM_CS(NUM_CS)) u_csel_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .cs_n       (cs_n),
    .xfer_ack   (xfer_ack)
);

// File: tb/tb_chipsel_unit.sv
// Bench for chipsel_unit: a behavioural reference model stepped on every
// rising edge and compared with the outputs every cycle, plus directed checks.
module tb_chipsel_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 6;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    boot_cfg = 3'b000;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [1:0]    reg_field = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic          xfer_start = 1'b0;
    logic [CW-1:0] xfer_addr_hi = '0;
    logic          ext_ack = 1'b0;
    logic [NCS-1:0] cs_n;
    logic          xfer_ack;
    logic [1:0]    xfer_psize;
    logic          xfer_burst;

    chipsel_unit dut (
        .clk(clk), .rst_n(rst_n), .boot_cfg(boot_cfg),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_field(reg_field),
        .reg_wdata(reg_wdata), .xfer_start(xfer_start),
        .xfer_addr_hi(xfer_addr_hi), .ext_ack(ext_ack),
        .cs_n(cs_n), .xfer_ack(xfer_ack), .xfer_psize(xfer_psize),
        .xfer_burst(xfer_burst)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int  m_base [NCS];
    int  m_mask [NCS];
    int  m_ctrl [NCS];
    bit  m_global, m_busy, m_int, m_burst, m_ackv, model_on;
    int  m_sel, m_cnt, m_ps, m_win;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCS; k++) begin
                m_base[k] = 0; m_mask[k] = 0; m_ctrl[k] = 0;
            end
            m_ctrl[0] = 1 | (int'(boot_cfg[1:0]) << 1) | (int'(boot_cfg[2]) << 4);
            m_global = 1'b1;
            m_busy = 1'b0;
        end else begin
            if (m_busy) begin
                m_ackv = m_int ? (m_cnt == 0) : ext_ack;
                if (m_ackv) m_busy = 1'b0;
                else if (m_int && m_cnt > 0) m_cnt--;
            end else if (xfer_start) begin
                m_win = -1;
                for (int k = NCS - 1; k >= 0; k--) begin
                    if ((m_ctrl[k] & 1) != 0 &&
                        ((k == 0 && m_global) ||
                         (((int'(xfer_addr_hi) ^ m_base[k]) & ~m_mask[k] & 16'hFFFF) == 0)))
                        m_win = k;
                end
                if (m_win >= 0) begin
                    m_busy  = 1'b1;
                    m_sel   = m_win;
                    m_ps    = (m_ctrl[m_win] >> 1) & 3;
                    m_burst = ((m_ctrl[m_win] >> 3) & 1) != 0;
                    m_int   = ((m_ctrl[m_win] >> 4) & 1) != 0;
                    m_cnt   = (m_ctrl[m_win] >> 5) & 16'h07FF;
                end
            end
            if (reg_we && reg_sel < NCS) begin
                case (reg_field)
                    2'd0: begin m_base[reg_sel] = int'(reg_wdata); if (reg_sel == 0) m_global = 1'b0; end
                    2'd1: m_mask[reg_sel] = int'(reg_wdata);
                    2'd2: m_ctrl[reg_sel] = int'(reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    // Every-cycle comparison, a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD / 4);
        if (model_on) begin
            int exp_cs, exp_ps;
            bit exp_ack, exp_b;
            exp_cs  = m_busy ? (~(1 << m_sel) & 6'h3F) : 6'h3F;
            exp_ack = m_busy && (m_int ? (m_cnt == 0) : ext_ack);
            exp_ps  = m_busy ? m_ps : 0;
            exp_b   = m_busy && m_burst;
            check(cs_n == exp_cs[5:0], "R10 model cs_n", int'(cs_n), exp_cs);
            check(xfer_ack == exp_ack, "R8 model ack", int'(xfer_ack), int'(exp_ack));
            check(xfer_psize == exp_ps[1:0], "R12 model psize", int'(xfer_psize), exp_ps);
            check(xfer_burst == exp_b, "R12 model burst", int'(xfer_burst), int'(exp_b));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic nxt();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [2:0] cfg);
        model_on = 1'b0;
        rst_n = 1'b0;
        boot_cfg = cfg;
        repeat (3) nxt();
        rst_n = 1'b1;
        boot_cfg = ~cfg;
        nxt();
        model_on = 1'b1;
    endtask

    task automatic wr(input int sel, input int fld, input int data);
        reg_we = 1'b1;
        reg_sel = 3'(sel);
        reg_field = 2'(fld);
        reg_wdata = 16'(data);
        nxt();
        reg_we = 1'b0;
    endtask

    task automatic go(input int addr);
        xfer_start = 1'b1;
        xfer_addr_hi = 16'(addr);
        nxt();
        xfer_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        do_reset(3'b101);
        check(cs_n == 6'h3F, "R1 cs_n after reset", int'(cs_n), 'h3F);
        check(xfer_ack == 1'b0, "R1 ack after reset", int'(xfer_ack), 0);

        // R2: boot select answers an arbitrary address, internal, size 01
        go('hABCD);
        check(cs_n == 6'h3E, "R2 boot match-any", int'(cs_n), 'h3E);
        check(xfer_ack == 1'b1, "R2 boot internal zero wait", int'(xfer_ack), 1);
        check(xfer_psize == 2'd1, "R2 boot port size", int'(xfer_psize), 1);
        nxt();
        check(cs_n == 6'h3F, "R10 release after ack", int'(cs_n), 'h3F);

        // Select 1: base 0x1000, mask 0x00FF, en, size 2, burst, internal, 3 waits
        wr(1, 0, 'h1000);
        wr(1, 1, 'h00FF);
        wr(1, 2, 125);
        go('h10AB);
        check(cs_n == 6'h3E, "R6 boot select 0 outranks select 1", int'(cs_n), 'h3E);
        nxt();

        // R3: writing select 0 base ends match-any
        wr(0, 0, 'h8000);
        go('h10AB);
        check(cs_n == 6'h3D, "R3 select 1 after boot mode ends", int'(cs_n), 'h3D);
        check(xfer_ack == 1'b0, "R8 no ack in first wait cycle", int'(xfer_ack), 0);
        check(xfer_psize == 2'd2 && xfer_burst, "R12 size and burst shown",
              {xfer_psize, xfer_burst}, 5);
        xfer_start = 1'b1;
        xfer_addr_hi = 16'h8000;
        nxt();
        xfer_start = 1'b0;
        check(cs_n == 6'h3D, "R11 start ignored while busy", int'(cs_n), 'h3D);
        nxt();
        check(xfer_ack == 1'b0, "R8 no ack in third cycle", int'(xfer_ack), 0);
        nxt();
        check(xfer_ack == 1'b1, "R8 ack after three waits", int'(xfer_ack), 1);
        nxt();
        check(cs_n == 6'h3F, "R10 release after waited ack", int'(cs_n), 'h3F);

        // R4 / R7: unmasked bit differs -> nothing selected
        go('h11AB);
        check(cs_n == 6'h3F, "R4 unmasked bit mismatch", int'(cs_n), 'h3F);
        check(xfer_ack == 1'b0, "R7 no ack on miss", int'(xfer_ack), 0);
        nxt();
        check(cs_n == 6'h3F, "R7 still idle after miss", int'(cs_n), 'h3F);
        go('h8000);
        check(cs_n == 6'h3E, "R3 select 0 by base", int'(cs_n), 'h3E);
        nxt();
        go('h10FF);
        check(cs_n == 6'h3D, "R4 masked bits ignored", int'(cs_n), 'h3D);
        repeat (4) nxt();

        // R5: disabled window never selects
        wr(2, 0, 'h2000);
        wr(2, 2, 'h0010);
        go('h2000);
        check(cs_n == 6'h3F, "R5 disabled select stays high", int'(cs_n), 'h3F);
        nxt();

        // R13 / R9: enable select 2 with external termination
        wr(2, 2, 1);
        wr(2, 3, 0);
        go('h2000);
        check(cs_n == 6'h3B, "R13 enable bit and index decode", int'(cs_n), 'h3B);
        check(xfer_ack == 1'b0, "R9 waits for device", int'(xfer_ack), 0);
        repeat (3) nxt();
        check(cs_n == 6'h3B && !xfer_ack, "R9 held without device ack",
              {cs_n, xfer_ack}, 'h76);
        ext_ack = 1'b1;
        #1;
        check(xfer_ack == 1'b1, "R9 ack follows device", int'(xfer_ack), 1);
        nxt();
        ext_ack = 1'b0;
        check(cs_n == 6'h3F, "R9 released after device ack", int'(cs_n), 'h3F);

        // R6: overlapping window on select 3
        wr(3, 0, 'h2000);
        wr(3, 1, 'hFFFF);
        wr(3, 2, 17);
        go('h2000);
        check(cs_n == 6'h3B, "R6 lower index wins overlap", int'(cs_n), 'h3B);
        ext_ack = 1'b1;
        nxt();
        ext_ack = 1'b0;
        go('h5555);
        check(cs_n == 6'h37, "R6 select 3 alone", int'(cs_n), 'h37);
        check(xfer_ack == 1'b1, "R8 select 3 internal zero wait", int'(xfer_ack), 1);
        nxt();

        // Second reset: external boot, size 2; programming cleared
        do_reset(3'b010);
        ext_ack = 1'b1;
        #1;
        check(xfer_ack == 1'b0, "R8 ext_ack ignored when idle", int'(xfer_ack), 0);
        ext_ack = 1'b0;
        go('h1234);
        check(cs_n == 6'h3E && xfer_psize == 2'd2, "R2 boot external size 2",
              {cs_n, xfer_psize}, 'hFA);
        check(xfer_ack == 1'b0, "R2 external boot waits", int'(xfer_ack), 0);
        ext_ack = 1'b1;
        nxt();
        ext_ack = 1'b0;
        wr(0, 0, 'h8000);
        go('h10AB);
        check(cs_n == 6'h3F, "R1 reset cleared select 1", int'(cs_n), 'h3F);
        repeat (2) nxt();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule